// File: doc/BRIEF.md
# Dual-Timer Frequency Ratio Counter

The block measures an unknown oscillator against a known reference using two 16-bit up-counters that start and stop together. Timer B counts rising edges of an asynchronous oscillator input, after a two-flop synchronizer. Timer A counts ticks of a reference taken from an internal prescaler, where a 3-bit select picks the system clock divided by 1, 2, 4, 8, 16, 32, 64 or 128. Software preloads both timers, sets the run bit, and waits for the interrupt. Each timer can be preloaded near its top, so whichever timer reaches its terminal count first sets the measurement window. The value left in the other timer then gives the frequency ratio.

When either timer wraps, both freeze, the run bit drops and a sticky interrupt flag is raised. Software reads and writes the 16-bit values one byte at a time over an 8-bit register port. A per-timer low-byte buffer makes each transfer atomic. While a measurement runs, the timer byte registers are locked.

Top module: `freq_ratio_timer`

## Requirements
- R1: A write to a timer's low-byte register (address 1 for Timer A, 3 for Timer B) loads only that timer's low buffer and leaves the counter unchanged.
- R2: A write to a timer's high-byte register (address 2 for Timer A, 4 for Timer B) loads the counter with the written byte as bits 15:8 and the buffered byte as bits 7:0.
- R3: A read of a high-byte register returns the live bits 15:8 and, at that clock edge, copies the live bits 7:0 into the timer's low buffer. A read of a low-byte register returns the buffer, never the live low byte.
- R4: The control register at address 0 holds the run bit in bit 0 and the Timer A source select in bits 3:1. While running, Timer A advances once every 2^select clock cycles. The prescaler restarts from zero whenever the block is not running, so a preload V overflows exactly (65536-V)*2^select cycles after the write that sets run.
- R5: While running, Timer B advances once for each rising edge of osc_i.
- R6: When either timer wraps from 0xFFFF, the flag (control bit 7, also driven on irq_o) is set and the run bit is cleared at the same edge. After that edge both counters hold their values.
- R7: While the run bit is set, writes to addresses 1 to 4 are ignored, reads of addresses 1 to 4 return 0, and those reads do not change the buffers.
- R8: The flag stays set until a control write carries 0 in bit 7. A 1 in bit 7 leaves it unchanged. When a hardware set and a software clear fall in the same cycle, the set wins. The same-cycle overflow also wins over a write of 1 to the run bit.
- R9: When both timers wrap in the same cycle, both counters end at 0 and the flag is set.
- R10: After reset, the control register reads 0, both counters and both buffers are 0, and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, also the prescaler source |
| rst_ni | input | 1 | Asynchronous active-low reset |
| osc_i | input | 1 | Asynchronous oscillator input counted by Timer B |
| addr_i | input | 3 | Register address: 0 control, 1/2 Timer A low/high, 3/4 Timer B low/high |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i while rd_en_i is high |
| irq_o | output | 1 | Sticky measurement-done flag |

## Verification
Two events can fall in the same cycle: the hardware overflow that sets the flag and clears run, and a software control write that clears the flag and sets run. The bench preloads Timer A to 0xFFF0 with divide-by-1 and starts it. It then places a control write carrying flag 0 and run 1 so that the write is sampled at exactly the sixteenth edge, the edge on which Timer A wraps. Afterwards the control register must show the flag set and run cleared. A second coincidence, both timers wrapping at one edge, is staged by timing the oscillator edge through the synchronizer so that it lands on the first running cycle.

// File: rtl/frt_pkg.sv
package frt_pkg;
  parameter int unsigned DW = 8;
  parameter int unsigned CW = 16;
  parameter int unsigned AW = 3;
  parameter int unsigned SW = 3;

  localparam int unsigned RUN_BIT  = 0;
  localparam int unsigned SEL_LSB  = 1;
  localparam int unsigned FLAG_BIT = 7;

  typedef enum logic [AW-1:0] {
    REG_CTRL = 3'd0,
    REG_A_LO = 3'd1,
    REG_A_HI = 3'd2,
    REG_B_LO = 3'd3,
    REG_B_HI = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/frt_prescaler.sv
module frt_prescaler #(
  parameter int unsigned SW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [SW-1:0] sel_i,
  output logic          tick_o
);
  localparam int unsigned PW = (1 << SW) - 1;

  logic [PW-1:0] presc_q;
  logic [PW-1:0] mask;

  always_comb begin
    mask   = PW'((1 << sel_i) - 1);
    tick_o = run_i && ((presc_q & mask) == mask);
  end

  // restart phase while idle so the first window is deterministic
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    presc_q <= '0;
    else if (run_i) presc_q <= presc_q + 1'b1;
    else            presc_q <= '0;
  end
endmodule

// File: rtl/frt_edge_sync.sv
module frt_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= async_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~prev_q;
endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = inc_i & (&cnt_q);
endmodule

// File: rtl/freq_ratio_timer.sv
module freq_ratio_timer
  import frt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          osc_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic          run_q, flag_q;
  logic [SW-1:0] sel_q;
  logic [DW-1:0] buf_a_q, buf_b_q;
  logic [CW-1:0] cnt_a, cnt_b;
  logic          tick_a, rise_b, inc_a, inc_b;
  logic          ovf_a, ovf_b, any_ovf;
  logic          unlocked, wr_ctrl;
  logic          ld_a, ld_b, wbuf_a, wbuf_b, cap_a, cap_b;

  frt_prescaler #(.SW(SW)) u_presc (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(run_q), .sel_i(sel_q), .tick_o(tick_a)
  );

  frt_edge_sync u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(osc_i), .rise_o(rise_b)
  );

  assign inc_a = tick_a;
  assign inc_b = run_q & rise_b;

  frt_counter #(.CW(CW)) u_cnt_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc_a), .load_i(ld_a),
    .load_val_i({wdata_i, buf_a_q}), .cnt_o(cnt_a), .ovf_o(ovf_a)
  );

  frt_counter #(.CW(CW)) u_cnt_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc_b), .load_i(ld_b),
    .load_val_i({wdata_i, buf_b_q}), .cnt_o(cnt_b), .ovf_o(ovf_b)
  );

  assign any_ovf  = ovf_a | ovf_b;
  assign unlocked = ~run_q;
  assign wr_ctrl  = wr_en_i && (addr_i == REG_CTRL);
  assign wbuf_a   = unlocked && wr_en_i && (addr_i == REG_A_LO);
  assign wbuf_b   = unlocked && wr_en_i && (addr_i == REG_B_LO);
  assign ld_a     = unlocked && wr_en_i && (addr_i == REG_A_HI);
  assign ld_b     = unlocked && wr_en_i && (addr_i == REG_B_HI);
  assign cap_a    = unlocked && rd_en_i && (addr_i == REG_A_HI);
  assign cap_b    = unlocked && rd_en_i && (addr_i == REG_B_HI);

  // overflow takes priority over any software write to run or flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      flag_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      if (wr_ctrl) sel_q <= wdata_i[SEL_LSB +: SW];
      if (any_ovf)      run_q <= 1'b0;
      else if (wr_ctrl) run_q <= wdata_i[RUN_BIT];
      if (any_ovf)                              flag_q <= 1'b1;
      else if (wr_ctrl && !wdata_i[FLAG_BIT])   flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_a_q <= '0;
      buf_b_q <= '0;
    end else begin
      if (wbuf_a)     buf_a_q <= wdata_i;
      else if (cap_a) buf_a_q <= cnt_a[DW-1:0];
      if (wbuf_b)     buf_b_q <= wdata_i;
      else if (cap_b) buf_b_q <= cnt_b[DW-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        REG_CTRL: begin
          rdata_o[RUN_BIT]             = run_q;
          rdata_o[SEL_LSB +: SW]       = sel_q;
          rdata_o[FLAG_BIT]            = flag_q;
        end
        REG_A_LO: if (unlocked) rdata_o = buf_a_q;
        REG_A_HI: if (unlocked) rdata_o = cnt_a[CW-1:DW];
        REG_B_LO: if (unlocked) rdata_o = buf_b_q;
        REG_B_HI: if (unlocked) rdata_o = cnt_b[CW-1:DW];
        default:  rdata_o = '0;
      endcase
    end
  end

  assign irq_o = flag_q;
endmodule

// File: rtl/frt_checker.sv
module frt_checker
  import frt_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          run_q,
  input logic          flag_q,
  input logic          rd_en_i,
  input logic          wr_en_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic [CW-1:0] cnt_a,
  input logic [CW-1:0] cnt_b,
  input logic          ovf_a,
  input logic          ovf_b,
  input logic [DW-1:0] buf_a_q,
  input logic          ld_a,
  input logic          ld_b
);
  // R6
  ovf_stops_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_a || ovf_b) |=> (!run_q && flag_q));

  // R6
  idle_hold_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !ld_a) |=> (cnt_a == $past(cnt_a)));

  // R6
  idle_hold_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !ld_b) |=> (cnt_b == $past(cnt_b)));

  // R7
  locked_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && rd_en_i && addr_i != REG_CTRL) |-> (rdata_o == '0));

  // R8
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(wr_en_i && addr_i == REG_CTRL && !wdata_i[FLAG_BIT])) |=> flag_q);

  // R2
  hi_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_a |=> (cnt_a == {$past(wdata_i), $past(buf_a_q)}));

  // R9
  dual_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_a && ovf_b) |=> (cnt_a == '0 && cnt_b == '0 && flag_q));
endmodule

bind freq_ratio_timer frt_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_q(run_q), .flag_q(flag_q),
  .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .cnt_a(cnt_a), .cnt_b(cnt_b), .ovf_a(ovf_a), .ovf_b(ovf_b),
  .buf_a_q(buf_a_q), .ld_a(ld_a), .ld_b(ld_b)
);

// File: tb/tb_freq_ratio_timer.sv
module tb_freq_ratio_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // {sel, a_init, b_init}
  localparam logic [39:0] VEC [NVEC] = '{
    {8'd0, 16'hFFF0, 16'h1234},
    {8'd2, 16'hFFF8, 16'h00AB},
    {8'd7, 16'hFFFE, 16'hBEEF},
    {8'd3, 16'hFF00, 16'h7F80},
    {8'd5, 16'hFFC0, 16'h0001}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       osc_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  freq_ratio_timer dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .osc_i(osc_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    @(posedge clk_i); @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic load(input logic [2:0] lo, input logic [15:0] v);
    wr(lo, v[7:0]);
    wr(lo + 3'd1, v[15:8]);
  endtask

  task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
    logic [7:0] h, l;
    rd(lo + 3'd1, h);
    rd(lo, l);
    v = {h, l};
  endtask

  task automatic wait_irq(input int limit, output int n);
    n = 0;
    while (!irq_o && n < limit) begin
      @(posedge clk_i); n++; @(negedge clk_i);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] v;
    int n;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R10 reset state
    rd(3'd0, d); chk("R10 ctrl", d, 0);
    rd16(3'd1, v); chk("R10 timer A", v, 0);
    rd16(3'd3, v); chk("R10 timer B", v, 0);
    chk("R10 irq", irq_o, 0);

    // R1/R2/R3 buffered access
    load(3'd1, 16'h1234);
    wr(3'd1, 8'h99);
    rd(3'd1, d); chk("R3 low read is buffer", d, 8'h99);
    rd(3'd2, d); chk("R1 high byte unchanged", d, 8'h12);
    rd(3'd1, d); chk("R1 R3 live low captured", d, 8'h34);
    load(3'd3, 16'hA5C3);
    rd16(3'd3, v); chk("R2 timer B commit", v, 16'hA5C3);

    // vector table: Timer A sets the window, B static
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0]  sel;
      logic [15:0] ai, bi;
      int exp_n;
      {sel, ai, bi} = VEC[i];
      exp_n = (65536 - int'(ai)) << sel;
      load(3'd1, ai);
      load(3'd3, bi);
      wr(3'd0, {4'b0, sel[2:0], 1'b1});
      wait_irq(exp_n + 50, n);
      chk("R4 window length", n, exp_n);
      rd(3'd0, d); chk("R6 flag set run clear", d, {1'b1, 3'b0, sel[2:0], 1'b0});
      repeat (5) @(negedge clk_i);
      rd16(3'd1, v); chk("R6 timer A wrapped", v, 0);
      rd16(3'd3, v); chk("R6 timer B held", v, bi);
      wr(3'd0, {1'b1, 3'b0, sel[2:0], 1'b0});
      chk("R8 write one keeps flag", irq_o, 1);
      wr(3'd0, {4'b0, sel[2:0], 1'b0});
      chk("R8 write zero clears", irq_o, 0);
    end

    // R5 Timer B counts oscillator edges and sets the window
    load(3'd1, 16'h0000);
    load(3'd3, 16'hFFF0);
    wr(3'd0, {4'b0, 3'd7, 1'b1});
    n = 0;
    while (!irq_o && n < 400) begin
      @(negedge clk_i); @(negedge clk_i); @(negedge clk_i);
      osc_i = ~osc_i; n++;
    end
    osc_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk("R5 flag from timer B", irq_o, 1);
    rd16(3'd3, v); chk("R5 timer B wrapped", v, 0);
    rd16(3'd1, v); chk("R6 timer A stopped", v, 0);
    wr(3'd0, 8'h00);

    // R7 lock while running
    load(3'd1, 16'h0000);
    wr(3'd0, {4'b0, 3'd7, 1'b1});
    wr(3'd2, 8'h55);
    wr(3'd1, 8'h66);
    rd(3'd2, d); chk("R7 locked read zero", d, 0);
    wr(3'd0, {4'b0, 3'd7, 1'b0});
    rd(3'd1, d); chk("R7 buffer untouched", d, 0);
    rd(3'd2, d); chk("R7 counter untouched", d, 0);

    // R8 same-cycle overflow vs clear/run write
    load(3'd1, 16'hFFF0);
    load(3'd3, 16'h0000);
    wr(3'd0, 8'h01);
    repeat (15) begin @(posedge clk_i); @(negedge clk_i); end
    wr(3'd0, 8'h01);
    rd(3'd0, d); chk("R8 set beats clear, ovf beats run", d, 8'h80);
    wr(3'd0, 8'h00);

    // R9 both wrap at the same edge
    load(3'd1, 16'hFFFF);
    load(3'd3, 16'hFFFF);
    osc_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    wr(3'd0, 8'h01);
    wait_irq(20, n);
    chk("R9 window one cycle", n, 1);
    rd16(3'd1, v); chk("R9 timer A zero", v, 0);
    rd16(3'd3, v); chk("R9 timer B zero", v, 0);
    rd(3'd0, d); chk("R9 flag", d, 8'h80);
    osc_i = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule